// File: doc/BRIEF.md
# Dual-Register Pulse-Width Capture

This block measures how long a pulse on one input pin lasts. It samples one of several free-running 16-bit counter buses at the pulse's leading edge and again at its trailing edge. A polarity input decides which edge leads, so the block can time either high pulses or low pulses. The leading-edge sample is held in a hidden staging register. It moves to the register that software reads only when the trailing edge is captured. Software therefore always reads a start value and an end value that belong to the same pulse.

Software uses a small register port. Address 0 holds the trailing-edge time and address 1 holds the leading-edge time. Address 2 holds status. Address 3 returns the pulse width, which is the trailing-edge time minus the leading-edge time, wrapped to 16 bits. A done flag tells software that a new pair of values is ready. A separate input marks a 32-bit coherent access in progress; while it is high, the staged leading-edge value is not moved into its readable register.

The register port is a plain register interface. A read returns data in the same cycle as the address, and a write takes effect in one cycle. There is no back-pressure.

Top module: `pulse_width_capture`

## Requirements
- R1: Captures happen only when `mode` is 4'b0001. In every other mode, pin edges change no data register and never raise the flag.
- R2: When `edge_pol` is 0, the leading edge is the rising edge of the pin. When `edge_pol` is 1, the leading edge is the falling edge.
- R3: After reset, and after any cycle with `mode` 4'b0000, the block waits for a leading edge. A trailing edge that arrives before that leading edge is ignored.
- R4: A leading-edge capture stores the selected counter value in the staging register. It raises no flag and leaves the value read at address 1 unchanged.
- R5: The pin is sampled on the first rising clock edge after it changes. The capture lands on the third rising edge. On a trailing-edge capture, the counter value goes into register A (read at address 0), the flag rises, and the staging register is copied to the readable B register (address 1).
- R6: A read at address 1 returns the readable B register. A write at address 1 loads the staging register and the readable B register with the same value. A write at address 0 loads register A.
- R7: If captures continue while the flag is still set, A and B are overwritten with the newest pair and the flag stays set.
- R8: If `coh_busy` is high when a trailing edge is captured, the staging-to-readable copy waits. It happens on the first clock edge at which `coh_busy` is low.
- R9: Status bit 1 (address 2) and `pin_level_o` always show the synchronised level of the pin.
- R10: `bus_sel` chooses which counter bus is captured. Bus k occupies bits [16k+15:16k] of `cnt_buses`.
- R11: Status bit 0 is the flag. Writing 0 to it clears the flag only if software read address 2 with the flag at 1 before that write. A capture in the same cycle as the clearing write wins, and the flag stays set.
- R12: A read at address 3 returns A minus the readable B register, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Pin to be measured, asynchronous |
| edge_pol | input | 1 | 0: rising edge leads; 1: falling edge leads |
| mode | input | 4 | 0: off, resets sequencing; 1: measure |
| bus_sel | input | 2 | Counter bus select |
| cnt_buses | input | 64 | Four 16-bit counter buses, packed |
| coh_busy | input | 1 | 32-bit coherent access in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| flag_o | output | 1 | Measurement-done flag |
| pin_level_o | output | 1 | Synchronised pin level |

## Verification
The assertions assume that no leading-edge capture arrives while a deferred copy is still pending. In other words, every coherent access ends before the next pulse begins. A dedicated check makes this assumption visible. The stimulus keeps every coherent window shorter than the gap between edges. It holds each pin level and each counter value for at least four clocks, so every edge is caught and the captured value is known. The polarity and the idle level of the pin are changed only while the mode is off.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [MODE_W-1:0] MODE_PWIDTH = 4'h1;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_PIN_BIT  = 1;

  typedef enum logic [1:0] {
    ADDR_A     = 2'd0,
    ADDR_B     = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_WIDTH = 2'd3
  } reg_addr_e;

  typedef enum logic {
    SEQ_WAIT_LEAD  = 1'b0,
    SEQ_WAIT_TRAIL = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic lead;
    logic trail;
    logic level;
  } edge_evt_t;

endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync
  import pwc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_async,
  input  logic      pol,
  output edge_evt_t evt
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         rise;
  logic         fall;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], pin_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[MSB];
  end

  assign rise = sync_q[MSB] & ~prev_q;
  assign fall = ~sync_q[MSB] & prev_q;

  always_comb begin
    evt.level = sync_q[MSB];
    evt.lead  = pol ? fall : rise;
    evt.trail = pol ? rise : fall;
  end

endmodule

// File: rtl/pwc_bus_sel.sv
module pwc_bus_sel #(
  parameter int NUM_BUS = 4,
  parameter int CNT_W   = 16,
  localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic [NUM_BUS*CNT_W-1:0] buses,
  input  logic [SEL_W-1:0]         sel,
  output logic [CNT_W-1:0]         value
);

  logic [CNT_W-1:0] bus_arr [NUM_BUS];

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_unpack
    assign bus_arr[g] = buses[g*CNT_W +: CNT_W];
  end

  generate
    if ((1 << SEL_W) == NUM_BUS) begin : g_full
      assign value = bus_arr[sel];
    end else begin : g_partial
      always_comb begin
        value = '0;
        for (int k = 0; k < NUM_BUS; k++) begin
          if (int'(sel) == k) value = bus_arr[k];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pwc_flag_ctrl.sv
module pwc_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wflag,
  output logic flag
);

  logic flag_q;
  logic armed_q;
  logic clear_req;

  assign clear_req = stat_wr && !stat_wflag && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed_q <= 1'b0;
    else if (stat_wr)           armed_q <= 1'b0;
    else if (stat_rd && flag_q) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (set_evt)   flag_q <= 1'b1;
    else if (clear_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/pwc_capture_core.sv
module pwc_capture_core
  import pwc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              lead,
  input  logic              trail,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              coh_busy,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  a_o,
  output logic [CNT_W-1:0]  b2_o,
  output logic [CNT_W-1:0]  width_o,
  output logic              cap_lead_o,
  output logic              cap_trail_o,
  output logic              pend_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] a_q;
  logic [CNT_W-1:0] b1_q;
  logic [CNT_W-1:0] b2_q;
  logic             pend_q;
  logic             active;
  logic             off;
  logic             cap_lead;
  logic             cap_trail;
  logic             copy_now;

  assign active    = (mode == MODE_PWIDTH);
  assign off       = (mode == MODE_OFF);
  assign cap_lead  = active && (state_q == SEQ_WAIT_LEAD)  && lead;
  assign cap_trail = active && (state_q == SEQ_WAIT_TRAIL) && trail;
  assign copy_now  = (cap_trail || pend_q) && !coh_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= SEQ_WAIT_LEAD;
    else if (off)       state_q <= SEQ_WAIT_LEAD;
    else if (cap_lead)  state_q <= SEQ_WAIT_TRAIL;
    else if (cap_trail) state_q <= SEQ_WAIT_LEAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        b1_q <= '0;
    else if (cap_lead) b1_q <= cnt_val;
    else if (wr_b)     b1_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         a_q <= '0;
    else if (cap_trail) a_q <= cnt_val;
    else if (wr_a)      a_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        b2_q <= '0;
    else if (copy_now) b2_q <= b1_q;
    else if (wr_b)     b2_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (copy_now)  pend_q <= 1'b0;
    else if (cap_trail) pend_q <= 1'b1;
  end

  assign a_o         = a_q;
  assign b2_o        = b2_q;
  assign width_o     = a_q - b2_q;
  assign cap_lead_o  = cap_lead;
  assign cap_trail_o = cap_trail;
  assign pend_o      = pend_q;

endmodule

// File: rtl/pulse_width_capture.sv
module pulse_width_capture
  import pwc_pkg::*;
#(
  parameter int NUM_BUS     = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pin_in,
  input  logic                     edge_pol,
  input  logic [MODE_W-1:0]        mode,
  input  logic [SEL_W-1:0]         bus_sel,
  input  logic [NUM_BUS*CNT_W-1:0] cnt_buses,
  input  logic                     coh_busy,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [1:0]               reg_addr,
  input  logic [CNT_W-1:0]         reg_wdata,
  output logic [CNT_W-1:0]         reg_rdata,
  output logic                     flag_o,
  output logic                     pin_level_o
);

  edge_evt_t        evt;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] core_a;
  logic [CNT_W-1:0] core_b2;
  logic [CNT_W-1:0] core_width;
  logic             core_cap_lead;
  logic             core_cap_trail;
  logic             core_pend;
  logic             wr_a;
  logic             wr_b;
  logic             stat_wr;
  logic             stat_rd;

  assign wr_a    = reg_wr && (reg_addr == ADDR_A);
  assign wr_b    = reg_wr && (reg_addr == ADDR_B);
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  pwc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_in),
    .pol       (edge_pol),
    .evt       (evt)
  );

  pwc_bus_sel #(.NUM_BUS(NUM_BUS), .CNT_W(CNT_W)) u_mux (
    .buses (cnt_buses),
    .sel   (bus_sel),
    .value (cnt_val)
  );

  pwc_capture_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .lead        (evt.lead),
    .trail       (evt.trail),
    .cnt_val     (cnt_val),
    .coh_busy    (coh_busy),
    .wr_a        (wr_a),
    .wr_b        (wr_b),
    .wdata       (reg_wdata),
    .a_o         (core_a),
    .b2_o        (core_b2),
    .width_o     (core_width),
    .cap_lead_o  (core_cap_lead),
    .cap_trail_o (core_cap_trail),
    .pend_o      (core_pend)
  );

  pwc_flag_ctrl u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (core_cap_trail),
    .stat_rd    (stat_rd),
    .stat_wr    (stat_wr),
    .stat_wflag (reg_wdata[STAT_FLAG_BIT]),
    .flag       (flag_o)
  );

  assign pin_level_o = evt.level;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_A:     reg_rdata = core_a;
      ADDR_B:     reg_rdata = core_b2;
      ADDR_STAT: begin
        reg_rdata[STAT_FLAG_BIT] = flag_o;
        reg_rdata[STAT_PIN_BIT]  = evt.level;
      end
      default:    reg_rdata = core_width;
    endcase
  end

endmodule

// File: rtl/pulse_width_capture_chk.sv
module pulse_width_capture_chk
  import pwc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_in,
  input logic [MODE_W-1:0] mode,
  input logic              coh_busy,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              flag_o,
  input logic              pin_level_o,
  input logic              cap_lead,
  input logic              cap_trail,
  input logic              pend,
  input logic [CNT_W-1:0]  b2
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_FLAG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(mode) == MODE_PWIDTH); // R1

  AST_LEAD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lead && !flag_o) |=> !flag_o); // R4

  AST_LEAD_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lead && !pend && !(reg_wr && reg_addr == ADDR_B)) |=> $stable(b2)); // R4

  AST_TRAIL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trail |=> flag_o); // R11

  AST_B_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_busy && !(reg_wr && reg_addr == ADDR_B)) |=> $stable(b2)); // R8

  AST_NO_LEAD_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && cap_lead)); // R8

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> ($past(reg_wr) && $past(reg_addr) == ADDR_STAT)); // R11

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> pin_level_o == $past(pin_in, 2)); // R9

endmodule

bind pulse_width_capture pulse_width_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_in      (pin_in),
  .mode        (mode),
  .coh_busy    (coh_busy),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .flag_o      (flag_o),
  .pin_level_o (pin_level_o),
  .cap_lead    (core_cap_lead),
  .cap_trail   (core_cap_trail),
  .pend        (core_pend),
  .b2          (core_b2)
);

// File: tb/pulse_width_capture_bench.sv
module pulse_width_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        edge_pol = 1'b0;
  logic [3:0]  mode = 4'h0;
  logic [1:0]  bus_sel = 2'd0;
  logic [63:0] cnt_buses;
  logic        coh_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        flag_o;
  logic        pin_level_o;

  logic [15:0] bus_base = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int g = 0; g < 4; g++) cnt_buses[g*16 +: 16] = bus_base + 16'(g * 16'h1111);
  end

  pulse_width_capture u_pulse_width_capture (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_pol(edge_pol), .mode(mode),
    .bus_sel(bus_sel), .cnt_buses(cnt_buses), .coh_busy(coh_busy), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_o(flag_o), .pin_level_o(pin_level_o)
  );

  function automatic logic [15:0] exp_bus(input logic [15:0] base, input logic [1:0] sel);
    return base + 16'(sel) * 16'h1111;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drive_edge(input logic lvl, input logic [15:0] base);
    @(negedge clk);
    bus_base = base; pin_in = lvl;
    tick(4);
  endtask

  task automatic enter_measure(input logic pol);
    @(negedge clk);
    mode = 4'h0; edge_pol = pol; pin_in = pol;
    tick(4);
    mode = 4'h1;
    tick(1);
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    rd(2'd2, d);
    wr(2'd2, 16'h0000);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v1, v2, last_a, last_b;
    logic        pol;
    logic [1:0]  sel;
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // Reset state
    rd(2'd0, d); chk("reset A", d, 16'h0000);
    rd(2'd1, d); chk("reset B", d, 16'h0000);
    chk("reset flag", {15'b0, flag_o}, 16'd0);

    // R1: other mode ignores pulses
    mode = 4'h2;
    drive_edge(1'b1, 16'h1234); drive_edge(1'b0, 16'h2345);
    chk("R1 flag", {15'b0, flag_o}, 16'd0);
    rd(2'd0, d); chk("R1 A", d, 16'h0000);

    // R3: trailing edge before leading is ignored
    @(negedge clk); mode = 4'h0; edge_pol = 1'b0; pin_in = 1'b1; tick(4);
    mode = 4'h1; tick(1);
    drive_edge(1'b0, 16'h0AAA);
    chk("R3 flag", {15'b0, flag_o}, 16'd0);
    rd(2'd0, d); chk("R3 A", d, 16'h0000);

    // R2/R4/R5 positive pulse
    drive_edge(1'b1, 16'h0100);
    chk("R4 flag", {15'b0, flag_o}, 16'd0);
    rd(2'd1, d); chk("R4 B", d, 16'h0000);
    drive_edge(1'b0, 16'h0350);
    chk("R5 flag", {15'b0, flag_o}, 16'd1);
    rd(2'd0, d); chk("R5 A", d, 16'h0350);
    rd(2'd1, d); chk("R5 B", d, 16'h0100);
    rd(2'd3, d); chk("R12 width", d, 16'h0250);

    // R7: overwrite while flag set
    drive_edge(1'b1, 16'h1000); drive_edge(1'b0, 16'h1007);
    chk("R7 flag", {15'b0, flag_o}, 16'd1);
    rd(2'd0, d); chk("R7 A", d, 16'h1007);
    rd(2'd1, d); chk("R7 B", d, 16'h1000);

    // R11: write 0 without arming read does not clear
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0000);
    chk("R11 no-arm", {15'b0, flag_o}, 16'd1);
    clear_flag();
    chk("R11 clear", {15'b0, flag_o}, 16'd0);

    // R9: pin level status
    @(negedge clk); mode = 4'h0; pin_in = 1'b1; tick(3);
    chk("R9 pin port", {15'b0, pin_level_o}, 16'd1);
    rd(2'd2, d); chk("R9 status", d, 16'h0002);
    @(negedge clk); pin_in = 1'b0; tick(3);
    chk("R9 pin low", {15'b0, pin_level_o}, 16'd0);

    // R2: negative pulse, wrap of width (R12)
    enter_measure(1'b1);
    drive_edge(1'b0, 16'hFFF0); drive_edge(1'b1, 16'h0010);
    rd(2'd0, d); chk("R2 A", d, 16'h0010);
    rd(2'd1, d); chk("R2 B", d, 16'hFFF0);
    rd(2'd3, d); chk("R12 wrap", d, 16'h0020);
    clear_flag();

    // R6: write B loads staging and readable registers
    enter_measure(1'b0);
    drive_edge(1'b1, 16'h0500);
    wr(2'd1, 16'h4321);
    rd(2'd1, d); chk("R6 B write", d, 16'h4321);
    drive_edge(1'b0, 16'h0600);
    rd(2'd1, d); chk("R6 B1 write", d, 16'h4321);
    wr(2'd0, 16'h7777);
    rd(2'd0, d); chk("R6 A write", d, 16'h7777);
    clear_flag();

    // R3: mode 0 resets sequencing
    drive_edge(1'b1, 16'h0800);
    @(negedge clk); mode = 4'h0; tick(1); mode = 4'h1; tick(1);
    drive_edge(1'b0, 16'h0900);
    chk("R3 reseq flag", {15'b0, flag_o}, 16'd0);
    rd(2'd0, d); chk("R3 reseq A", d, 16'h7777);

    // R8: deferred copy under coherent access
    last_b = 16'h4321;
    drive_edge(1'b1, 16'h2000);
    @(negedge clk); coh_busy = 1'b1;
    drive_edge(1'b0, 16'h2222);
    chk("R8 flag", {15'b0, flag_o}, 16'd1);
    rd(2'd0, d); chk("R8 A", d, 16'h2222);
    rd(2'd1, d); chk("R8 B held", d, last_b);
    @(negedge clk); coh_busy = 1'b0; tick(2);
    rd(2'd1, d); chk("R8 B after", d, 16'h2000);

    // R11: capture in same cycle as clearing write keeps flag
    rd(2'd2, d);
    drive_edge(1'b1, 16'h3000);
    @(negedge clk); bus_base = 16'h3100; pin_in = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_addr = 2'd2; reg_wdata = 16'h0000; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    tick(2);
    chk("R11 priority", {15'b0, flag_o}, 16'd1);
    rd(2'd0, d); chk("R11 priority A", d, 16'h3100);
    clear_flag();

    // R10: bus select
    @(negedge clk); bus_sel = 2'd2;
    enter_measure(1'b0);
    drive_edge(1'b1, 16'h0040); drive_edge(1'b0, 16'h0090);
    rd(2'd1, d); chk("R10 B", d, exp_bus(16'h0040, 2'd2));
    rd(2'd0, d); chk("R10 A", d, exp_bus(16'h0090, 2'd2));
    clear_flag();

    // Random pulses: R2 R5 R10 R12
    for (int i = 0; i < 40; i++) begin
      pol = 1'($urandom % 2);
      sel = 2'($urandom % 4);
      v1 = 16'($urandom);
      v2 = 16'($urandom);
      @(negedge clk); bus_sel = sel;
      enter_measure(pol);
      drive_edge(~pol, v1);
      drive_edge(pol, v2);
      last_a = exp_bus(v2, sel);
      last_b = exp_bus(v1, sel);
      chk("R5 rnd flag", {15'b0, flag_o}, 16'd1);
      rd(2'd0, d); chk("R5 rnd A", d, last_a);
      rd(2'd1, d); chk("R10 rnd B", d, last_b);
      rd(2'd3, d); chk("R12 rnd width", d, last_a - last_b);
      clear_flag();
      chk("R11 rnd clear", {15'b0, flag_o}, 16'd0);
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule